// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 256K words by 16 bits. A requester presents an address, write data, a two-bit lane mask and a read/write flag under a valid/ready handshake. The controller turns each accepted request into one timed memory cycle on the chip-enable, write-enable, output-enable and per-byte enable pins, and it drives or releases the shared 16-bit data bus. Reads come back on a separate data port with a single-clock valid strobe.

Each read or write phase is stretched by a wait-state count derived from two parameters, the system clock period and the memory access time, so the same logic fits any clock. For writes, the address, lane enables and data settle one clock before write enable falls and stay one clock after it rises. A write that follows a read waits one extra idle clock so that the memory has released the bus before the controller drives it. Only one access is in flight at a time, and whenever no access is running the memory is deselected.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no access runs, req_ready is 1, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n and mem_lb_n are all 1, rsp_valid is 0, and the controller does not drive mem_dq.
- R2: An accepted write with a non-zero mask gives one setup clock (mem_ce_n low, mem_we_n high, data driven), then mem_we_n low for exactly WAIT_CYC clocks, then one hold clock with mem_we_n high. Address, lane enables and data do not change from the setup clock to the hold clock. mem_we_n is first low in the second clock after the accepting edge.
- R3: Mask bit 0 selects data bits 7:0 and drives mem_lb_n low; mask bit 1 selects bits 15:8 and drives mem_ub_n low. A lane whose mask bit is 0 is left unchanged in memory by a write.
- R4: An accepted read with a non-zero mask holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly WAIT_CYC clocks. The data is sampled at the edge that ends the last of those clocks, and rsp_valid is high for one clock in the (WAIT_CYC+1)th clock after the accepting edge.
- R5: In returned read data, a lane whose mask bit was 0 is zero whatever the bus carried.
- R6: A request with mask 2'b00 runs no memory cycle: mem_ce_n stays high and req_ready stays high. If it is a read, rsp_valid pulses in the first clock after acceptance with all-zero data.
- R7: A write accepted while the most recent memory cycle was a read gets one turnaround clock with mem_ce_n and mem_oe_n high and the bus released before its setup clock, so mem_we_n first falls in the third clock after acceptance.
- R8: WAIT_CYC is ACCESS_NS divided by CLK_PERIOD_NS rounded up, at least 1; with the defaults (55 ns, 20 ns) it is 3.
- R9: req_ready is low from the clock after a non-zero-mask request is accepted until its memory cycle ends: WAIT_CYC+2 clocks for a write (one more with a turnaround), WAIT_CYC clocks for a read.
- R10: The controller drives mem_dq only during the setup, write-enable-low and hold clocks of a write; mem_oe_n is never low while mem_we_n is low or while the controller drives the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Active-high lane select, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid, one-clock pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
Full-word writes and reads at the lowest and highest address and at every single-bit address separate a working address path from stuck or swapped address lines. Single-lane writes over known contents, followed by full and single-lane reads while the memory model puts junk on the disabled lane, tell correct lane enables and read masking apart from swapped or ignored lanes. Write-after-write versus write-after-read latencies tell the turnaround clock apart from none or an unconditional one, and zero-mask reads and writes tell a skipped memory cycle apart from a spurious one.

// File: rtl/sram_lane_pkg.sv
// Shared types for the byte-lane SRAM controller.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package sram_lane_pkg;

    // Sequencer phases of one memory access.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_SETUP = 3'd2,
        ST_WRITE = 3'd3,
        ST_HOLD  = 3'd4,
        ST_READ  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/sram_wait_timer.sv
// Wait-state timer: counts clocks while a timed phase runs and flags the
// last one. Assumes CYCLES >= 1 and that run drops for at least one clock
// between phases or that the phase ends on last.
module sram_wait_timer #(
    parameter int unsigned CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == LAST_VAL);

    // Count clocks of the running phase, restart when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R8
    // cnt_in_range_chk: the count never passes the last wait state
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST_VAL));

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks one memory access through turnaround, setup,
// write-enable, hold or read phases and decodes the control pins.
// Assumes start is only raised while ready_o is high and the mask is non-zero.
module sram_seq_fsm
    import sram_lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_write,
    input  logic phase_last,
    output logic ready_o,
    output logic run_o,
    output logic cap_o,
    output logic drive_o,
    output logic ce_n_o,
    output logic we_n_o,
    output logic oe_n_o
);
    seq_state_t state_q, state_d;
    logic       last_rd_q;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = start_write ? (last_rd_q ? ST_TURN : ST_SETUP) : ST_READ;
            ST_TURN:  state_d = ST_SETUP;
            ST_SETUP: state_d = ST_WRITE;
            ST_WRITE: if (phase_last) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_IDLE;
            ST_READ:  if (phase_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remember whether the latest memory cycle was a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_rd_q <= 1'b0;
        else if (state_q == ST_READ)  last_rd_q <= 1'b1;
        else if (state_q == ST_WRITE) last_rd_q <= 1'b0;
    end

    // Pin and strobe decode from the current phase.
    always_comb begin
        ready_o = (state_q == ST_IDLE);
        run_o   = (state_q == ST_WRITE) || (state_q == ST_READ);
        cap_o   = (state_q == ST_READ) && phase_last;
        drive_o = (state_q == ST_SETUP) || (state_q == ST_WRITE) || (state_q == ST_HOLD);
        ce_n_o  = !(drive_o || (state_q == ST_READ));
        we_n_o  = (state_q != ST_WRITE);
        oe_n_o  = (state_q != ST_READ);
    end

    // R7
    // turn_after_read_chk: a turnaround clock only follows a read
    turn_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TURN) |-> last_rd_q && ce_n_o && oe_n_o && !drive_o);

endmodule

// File: rtl/sram_rd_capture.sv
// Read return path: samples the bus on the last read clock, zeroes the
// lanes that were not enabled and strobes the result for one clock.
// Assumes lane_en holds the mask of the access being captured.
module sram_rd_capture #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap,
    input  logic                      zero_rd,
    input  logic [LANES-1:0]          lane_en,
    input  logic [LANES*LANE_W-1:0]   dq_in,
    output logic                      rsp_valid_o,
    output logic [LANES*LANE_W-1:0]   rsp_data_o
);
    // Result strobe for a sampled or an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid_o <= 1'b0;
        else        rsp_valid_o <= cap || zero_rd;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane capture, disabled lanes forced to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)       rsp_data_o[i*LANE_W +: LANE_W] <= '0;
            else if (cap)     rsp_data_o[i*LANE_W +: LANE_W] <= lane_en[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
            else if (zero_rd) rsp_data_o[i*LANE_W +: LANE_W] <= '0;
        end

        // R5
        // lane_off_zero_chk: a lane left out of a read returns zero
        lane_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap && !lane_en[i]) |=> (rsp_data_o[i*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Byte-lane asynchronous SRAM controller top. Accepts one request at a
// time, registers it, and runs the timed memory cycle through the
// sequencer, wait timer and read capture. Assumes two byte lanes and a
// synchronous active-low reset; the bus is released unless a write runs.
module sram_lane_ctrl #(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned LANE_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned ACCESS_NS     = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    inout  wire  [2*LANE_W-1:0] mem_dq
);
    localparam int unsigned LANES    = 2;
    localparam int unsigned DATA_W   = LANES * LANE_W;
    localparam int unsigned WAIT_RAW = (ACCESS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    logic              accept, start_mem, zero_rd;
    logic              run, phase_last, cap, dq_drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    assign accept    = req_valid && req_ready;
    assign start_mem = accept && (|req_mask);
    assign zero_rd   = accept && !req_write && !(|req_mask);

    // Hold the accepted request for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (start_mem) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    sram_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_mem),
        .start_write(req_write),
        .phase_last (phase_last),
        .ready_o    (req_ready),
        .run_o      (run),
        .cap_o      (cap),
        .drive_o    (dq_drive),
        .ce_n_o     (mem_ce_n),
        .we_n_o     (mem_we_n),
        .oe_n_o     (mem_oe_n)
    );

    sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .last (phase_last)
    );

    sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .zero_rd    (zero_rd),
        .lane_en    (mask_q),
        .dq_in      (mem_dq),
        .rsp_valid_o(rsp_valid),
        .rsp_data_o (rsp_rdata)
    );

    // Memory pins: lanes only enabled while the chip is selected.
    assign mem_addr = addr_q;
    assign mem_lb_n = mem_ce_n || !mask_q[0];
    assign mem_ub_n = mem_ce_n || !mask_q[1];
    assign mem_dq   = dq_drive ? wdata_q : {DATA_W{1'bz}};

    // R1
    // idle_deselect_chk: no chip select while the controller is free
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_ub_n && mem_lb_n && !dq_drive));

    // R2
    // we_setup_chk: pins settled one clock before write enable falls
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n}) && $past(dq_drive)));

    // R2
    // we_hold_chk: pins held one clock after write enable rises
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n}) && dq_drive && !mem_ce_n));

    // R10
    // no_contend_chk: outputs enabled only with the bus released
    no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!dq_drive && mem_we_n));

    // R9
    // busy_after_accept_chk: one access outstanding at a time
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_mem |=> !req_ready);

    // R6
    // empty_mask_chk: a zero-mask request leaves the chip deselected
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(|req_mask)) |=> (req_ready && mem_ce_n));

endmodule

// File: tb/sram_lane_ctrl_test.sv
// Scoreboard bench: a driver task issues requests and queues expected read
// data from a shadow copy; a monitor pops and compares on each response.
module sram_lane_ctrl_test;
    localparam int WAIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    wire  [15:0] mem_dq;

    int total = 0;
    int bad = 0;
    int ce_low_cnt = 0;
    logic [15:0] exp_q[$];
    logic [15:0] shadow [int];
    logic [15:0] model_mem [int];

    always #10 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq(mem_dq)
    );

    // Memory model: stores enabled lanes at the end of write enable,
    // drives junk on disabled lanes during reads.
    logic        model_oe;
    logic [15:0] model_word, model_q;
    assign model_oe = !mem_ce_n && !mem_oe_n && mem_we_n;
    always_comb begin
        model_word = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
        model_q = {mem_ub_n ? 8'h5A : model_word[15:8], mem_lb_n ? 8'hC3 : model_word[7:0]};
    end
    assign mem_dq = model_oe ? model_q : 16'bz;

    always @(posedge mem_we_n) begin
        if (rst_n && mem_ce_n === 1'b0) begin
            logic [15:0] w;
            w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
            if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq[15:8];
            model_mem[int'(mem_addr)] = w;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: compare each response with the scoreboard queue; time pins.
    int we_run = 0;
    int oe_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) ce_low_cnt++;
            if (rsp_valid) begin
                if (exp_q.size() == 0) check("R4 unexpected response", 32'(rsp_rdata), 32'hDEAD);
                else check("R3/R5 read data", 32'(rsp_rdata), 32'(exp_q.pop_front()));
            end
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin check("R2 we low clocks", we_run, WAIT); we_run = 0; end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin check("R4 oe low clocks", oe_run, WAIT); oe_run = 0; end
            if (!mem_oe_n && !mem_we_n) check("R10 oe with we", 0, 1);
            if (req_ready && !mem_ce_n) check("R1 selected while idle", 0, 1);
        end
    end

    // Driver: issue one request, queue its expectation, measure timing.
    task automatic issue(input logic wr, input logic [17:0] a, input logic [1:0] m,
                         input logic [15:0] d, output int lat, output int busy);
        int n = 0;
        logic [15:0] sh;
        lat = 0; busy = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        while (!req_ready) @(negedge clk);
        sh = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (wr) begin
            if (m != 2'b00) shadow[int'(a)] = {m[1] ? d[15:8] : sh[15:8], m[0] ? d[7:0] : sh[7:0]};
        end else begin
            exp_q.push_back({m[1] ? sh[15:8] : 8'h00, m[0] ? sh[7:0] : 8'h00});
        end
        do begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (!req_ready) busy++;
            if (lat == 0 && (wr ? !mem_we_n : rsp_valid)) lat = n;
        end while (!(req_ready && (lat != 0 || m == 2'b00)) && n < 100);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int lat, busy, ce0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", req_ready, 1);
        check("R1 pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 5'b11111);
        check("R1 rsp_valid", rsp_valid, 0);

        // R2 R9 full writes, low and high address
        issue(1, 18'h00000, 2'b11, 16'h1234, lat, busy);
        check("R2 we fall clock", lat, 2);
        check("R9 write busy", busy, WAIT + 2);
        issue(1, 18'h3FFFF, 2'b11, 16'hABCD, lat, busy);
        check("R2 write-after-write latency", lat, 2);

        // R4 R9 R8 read timing
        issue(0, 18'h00000, 2'b11, 16'h0, lat, busy);
        check("R4 R8 read response clock", lat, WAIT + 1);
        check("R9 read busy", busy, WAIT);

        // R7 write after read gets a turnaround, R3 low lane only
        issue(1, 18'h00000, 2'b01, 16'hFF77, lat, busy);
        check("R7 turnaround latency", lat, 3);
        check("R9 write busy with turn", busy, WAIT + 3);
        issue(0, 18'h00000, 2'b11, 16'h0, lat, busy);
        // R3 high lane only, then R5 single-lane reads
        issue(1, 18'h3FFFF, 2'b10, 16'h55EE, lat, busy);
        check("R7 turnaround latency again", lat, 3);
        issue(0, 18'h3FFFF, 2'b10, 16'h0, lat, busy);
        issue(0, 18'h3FFFF, 2'b01, 16'h0, lat, busy);

        // R6 zero-mask write and read
        ce0 = ce_low_cnt;
        issue(1, 18'h00000, 2'b00, 16'h0000, lat, busy);
        @(negedge clk);
        check("R6 no cycle for empty write", ce_low_cnt, ce0);
        check("R6 empty write busy", busy, 0);
        issue(0, 18'h00000, 2'b00, 16'h0, lat, busy);
        check("R6 empty read response clock", lat, 1);
        check("R6 empty read busy", busy, 0);
        check("R6 no cycle for empty read", ce_low_cnt, ce0);
        issue(0, 18'h00000, 2'b11, 16'h0, lat, busy);

        // R2 R4 walking address bits
        for (int i = 0; i < 18; i++)
            issue(1, 18'(1) << i, 2'b11, 16'(16'h0101 * (i + 1)) ^ 16'h8000, lat, busy);
        for (int i = 0; i < 18; i++)
            issue(0, 18'(1) << i, 2'b11, 16'h0, lat, busy);
        issue(0, 18'h3FFFF, 2'b11, 16'h0, lat, busy);

        repeat (3) @(negedge clk);
        check("R4 all responses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule